// File: doc/BRIEF.md
# Iterative Bitsliced SPN Round Engine

This block runs the round function of a 128-bit substitution-permutation cipher, one round per clock. The state is held as four 32-bit words. In each round the current state is XORed with a round key, every one of the 32 bit columns is passed through a 4-bit S-box, and the result goes through a fixed chain of rotations, shifts and XORs that mixes the four words. The S-box used in a round is picked by the low three bits of the round number, out of eight fixed boxes.

The S-boxes are built as pure combinational logic on each column, with no table memory addressed by data, so every round takes the same time whatever the state and key. A caller pulses `start_i` with the input state. The engine then shows the round number on `ridx_o` and reads the matching round key from `rkey_i` in the same cycle, so a key store outside the block is addressed directly by `ridx_o`. After the last round, `done_o` pulses for one cycle. The result stays on `state_o` until the next run begins. Key scheduling and any final key whitening are done outside this block.

Top module: `spn_round_engine`

## Requirements
- R1: After reset `done_o` is 0, `ridx_o` is 0 and `state_o` is all zeros.
- R2: A `start_i` pulse while idle loads `state_i` and starts a run of 31 rounds, one per clock. In the k-th cycle after the start edge (k = 1..31), `ridx_o` equals k-1, and the key on `rkey_i` is used in that same cycle.
- R3: Each round computes state = MIX(SB[i mod 8](state XOR key[i])). Word w of a 128-bit value sits in bits [32w+31:32w].
- R4: For each column j (0..31), the S-box input nibble is {x3[j], x2[j], x1[j], x0[j]}, with word 0 as the LSB. Output bit k of the nibble is written back to bit j of word k.
- R5: The S-box tables list the outputs for inputs 0..15. SB0: 3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12. SB1: 15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4. SB2: 8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2. SB3: 0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14. SB4: 1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13. SB5: 15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1. SB6: 7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0. SB7: 1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6.
- R6: MIX runs these five step pairs in order, with rotations 32-bit circular and plain shifts zero-filled: x0 rotl 13, x2 rotl 3; x1 ^= x0^x2, x3 ^= x2^(x0<<3); x1 rotl 1, x3 rotl 7; x0 ^= x1^x3, x2 ^= x3^(x1<<7); x0 rotl 5, x2 rotl 22.
- R7: `done_o` is high for exactly one cycle, the 32nd cycle after the start edge. In that cycle and afterwards, until the next start, `state_o` holds the result of round 30.
- R8: A `start_i` pulse during a run is ignored. The run in progress ends at the same time with the same result.
- R9: MIX is a bijection, so a nonzero input never gives a zero output and a zero input always gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| state_i | input | 128 | Initial state, sampled with the start |
| rkey_i | input | 128 | Round key for the round shown on `ridx_o` |
| ridx_o | output | 5 | Current round number, addresses the key store |
| state_o | output | 128 | Working state, which is the result once done |
| done_o | output | 1 | One-cycle pulse when the last round completes |

## Verification
The assertions assume that `rkey_i` is a combinational function of `ridx_o` and that `start_i` is a clean one-cycle pulse. They make no assumption about when a start arrives relative to a run. The bench drives the key from its own per-run key array indexed by `ridx_o`, and changes every input only on the falling edge. It also deliberately raises a second start in the middle of one run, so the engine is exercised on a start it must ignore.

// File: rtl/spn_pkg.sv
package spn_pkg;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 4;
    localparam int STATE_W  = WORD_W * NWORDS;
    localparam int NBOXES   = 8;
    localparam int BOXSEL_W = $clog2(NBOXES);

    typedef logic [WORD_W-1:0] word_t;

    // nibble n of each constant is the output for input n
    localparam logic [63:0] SB0 = 64'hC90724DEB56A1F83;
    localparam logic [63:0] SB1 = 64'h43D68EB1A50972CF;
    localparam logic [63:0] SB2 = 64'h25B04E1DFAC39768;
    localparam logic [63:0] SB3 = 64'hE57A421D369C8BF0;
    localparam logic [63:0] SB4 = 64'hD7E9A4526B0C38F1;
    localparam logic [63:0] SB5 = 64'h176D8E30C9A4B25F;
    localparam logic [63:0] SB6 = 64'h0A3DF19EB6485C27;
    localparam logic [63:0] SB7 = 64'h6539AC47B28E0FD1;

    function automatic logic [3:0] sbox_eval(input logic [BOXSEL_W-1:0] sel,
                                             input logic [3:0] nib);
        logic [63:0] tab;
        case (sel)
            3'd0:    tab = SB0;
            3'd1:    tab = SB1;
            3'd2:    tab = SB2;
            3'd3:    tab = SB3;
            3'd4:    tab = SB4;
            3'd5:    tab = SB5;
            3'd6:    tab = SB6;
            default: tab = SB7;
        endcase
        return tab[{nib, 2'b00} +: 4];
    endfunction

    function automatic word_t rotl(input word_t v, input int unsigned amt);
        return (v << amt) | (v >> (WORD_W - amt));
    endfunction
endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
    import spn_pkg::*;
(
    input  logic [BOXSEL_W-1:0] sel_i,
    input  logic [STATE_W-1:0]  din_i,
    output logic [STATE_W-1:0]  dout_o
);
    // R4: one column per bit position, word 0 is the nibble LSB
    for (genvar j = 0; j < WORD_W; j++) begin : g_col
        logic [NWORDS-1:0] col_in;
        logic [NWORDS-1:0] col_out;
        for (genvar k = 0; k < NWORDS; k++) begin : g_gather
            assign col_in[k] = din_i[k*WORD_W + j];
            assign dout_o[k*WORD_W + j] = col_out[k];
        end
        assign col_out = sbox_eval(sel_i, col_in);
    end
endmodule

// File: rtl/spn_mix_layer.sv
module spn_mix_layer
    import spn_pkg::*;
(
    input  logic [STATE_W-1:0] din_i,
    output logic [STATE_W-1:0] dout_o
);
    word_t a, b, c, d;

    // R6: ordered in-place update of the four words
    always_comb begin
        a = din_i[0*WORD_W +: WORD_W];
        b = din_i[1*WORD_W +: WORD_W];
        c = din_i[2*WORD_W +: WORD_W];
        d = din_i[3*WORD_W +: WORD_W];
        a = rotl(a, 13);
        c = rotl(c, 3);
        b = b ^ a ^ c;
        d = d ^ c ^ (a << 3);
        b = rotl(b, 1);
        d = rotl(d, 7);
        a = a ^ b ^ d;
        c = c ^ d ^ (b << 7);
        a = rotl(a, 5);
        c = rotl(c, 22);
        dout_o = {d, c, b, a};
    end
endmodule

// File: rtl/spn_round_engine.sv
module spn_round_engine
    import spn_pkg::*;
#(
    parameter int ROUNDS = 31,
    localparam int RIDX_W = $clog2(ROUNDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [STATE_W-1:0]  state_i,
    input  logic [STATE_W-1:0]  rkey_i,
    output logic [RIDX_W-1:0]   ridx_o,
    output logic [STATE_W-1:0]  state_o,
    output logic                done_o
);
    localparam logic [RIDX_W-1:0] LAST = RIDX_W'(ROUNDS - 1);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [RIDX_W-1:0]  rnd;
        logic [STATE_W-1:0] st;
    } eng_t;

    eng_t r_d, r_q;

    logic [STATE_W-1:0]  keyed;
    logic [STATE_W-1:0]  subbed;
    logic [STATE_W-1:0]  mixed;
    logic [BOXSEL_W-1:0] box_sel;

    assign keyed   = r_q.st ^ rkey_i;
    assign box_sel = r_q.rnd[BOXSEL_W-1:0];

    spn_sbox_layer u_sbox (
        .sel_i  (box_sel),
        .din_i  (keyed),
        .dout_o (subbed)
    );

    spn_mix_layer u_mix (
        .din_i  (subbed),
        .dout_o (mixed)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.busy) begin
            r_d.st = mixed;
            if (r_q.rnd == LAST) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.rnd  = '0;
            end else begin
                r_d.rnd = r_q.rnd + RIDX_W'(1);
            end
        end else if (start_i) begin
            r_d.busy = 1'b1;
            r_d.rnd  = '0;
            r_d.st   = state_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ridx_o  = r_q.rnd;
    assign state_o = r_q.st;
    assign done_o  = r_q.done;

    a_r2_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.rnd != LAST) |=> (r_q.busy && r_q.rnd == $past(r_q.rnd) + RIDX_W'(1)));

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.rnd == LAST) |=> (done_o && !r_q.busy));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.busy && !start_i) |=> $stable(state_o));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && start_i && r_q.rnd != LAST) |=> (r_q.rnd != '0));

    a_r9_mix_bijective: assert property (@(posedge clk) disable iff (!rst_n)
        ((subbed == '0) == (mixed == '0)));
endmodule

// File: tb/sim_spn_round_engine.sv
module sim_spn_round_engine;
    localparam int NR = 31;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] state_i = '0;
    logic [127:0] rkey_i;
    logic [4:0]   ridx_o;
    logic [127:0] state_o;
    logic         done_o;

    logic [127:0] keys [32];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spn_round_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
        .rkey_i(rkey_i), .ridx_o(ridx_o), .state_o(state_o), .done_o(done_o)
    );

    always_comb rkey_i = keys[ridx_o];

    function automatic logic [3:0] ref_sbox(int box, logic [3:0] n);
        int t[16];
        case (box)
            0: t = '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12};
            1: t = '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4};
            2: t = '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2};
            3: t = '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14};
            4: t = '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13};
            5: t = '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1};
            6: t = '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0};
            default: t = '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6};
        endcase
        return 4'(t[n]);
    endfunction

    function automatic logic [31:0] rl(logic [31:0] v, int s);
        return {v, v} >> (32 - s);
    endfunction

    function automatic logic [127:0] ref_mix(logic [127:0] v);
        logic [31:0] t0, t1, t2, t3, t4, t5, t6, t7, t8, t9;
        t0 = rl(v[31:0], 13);
        t1 = rl(v[95:64], 3);
        t2 = v[63:32] ^ t0 ^ t1;
        t3 = v[127:96] ^ t1 ^ (t0 << 3);
        t4 = rl(t2, 1);
        t5 = rl(t3, 7);
        t6 = t0 ^ t4 ^ t5;
        t7 = t1 ^ t5 ^ (t4 << 7);
        t8 = rl(t6, 5);
        t9 = rl(t7, 22);
        return {t5, t9, t4, t8};
    endfunction

    function automatic logic [127:0] ref_round(logic [127:0] s, logic [127:0] k, int r);
        logic [127:0] x, y;
        x = s ^ k;
        y = '0;
        for (int j = 0; j < 32; j++) begin
            logic [3:0] o;
            o = ref_sbox(r % 8, {x[96+j], x[64+j], x[32+j], x[j]});
            y[j] = o[0]; y[32+j] = o[1]; y[64+j] = o[2]; y[96+j] = o[3];
        end
        return ref_mix(y);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one run; if disturb, a second start with other data is pulsed mid-run (R8)
    task automatic run(logic [127:0] pt, bit disturb);
        logic [127:0] exp;
        exp = pt;
        for (int r = 0; r < NR; r++) exp = ref_round(exp, keys[r], r);
        @(negedge clk);
        start_i = 1'b1;
        state_i = pt;
        for (int k = 1; k <= NR; k++) begin
            @(negedge clk);
            start_i = (disturb && k == 5);
            if (disturb && k == 5) state_i = ~pt;
            check(ridx_o == 5'(k - 1), "R2 ridx", 128'(ridx_o), 128'(k - 1));
            check(done_o == 1'b0, "R7 early done", 128'(done_o), 128'd0);
        end
        @(negedge clk);
        check(done_o == 1'b1, "R7 done", 128'(done_o), 128'd1);
        check(state_o == exp, disturb ? "R8 result" : "R3 result", state_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done width", 128'(done_o), 128'd0);
        check(state_o == exp, "R7 hold", state_o, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) keys[i] = '0;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done", 128'(done_o), 128'd0);
        check(ridx_o == 5'd0, "R1 ridx", 128'(ridx_o), 128'd0);
        check(state_o == '0, "R1 state", state_o, 128'd0);
        rst_n = 1'b1;
        // R4 R5 R6: zero data and keys, then all ones
        run('0, 1'b0);
        for (int i = 0; i < 32; i++) keys[i] = '1;
        run('1, 1'b0);
        // R4: single set bit in one column of one word
        for (int i = 0; i < 32; i++) keys[i] = '0;
        run(128'h1 << 77, 1'b0);
        // R3 R5: random keys and data across all boxes
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < 32; i++) keys[i] = rnd128();
            run(rnd128(), 1'b0);
        end
        // R8: start during a run is ignored
        for (int i = 0; i < 32; i++) keys[i] = rnd128();
        run(rnd128(), 1'b1);
        // R7: idle cycles keep the result
        begin
            logic [127:0] held;
            held = state_o;
            repeat (4) @(negedge clk);
            check(state_o == held && !done_o, "R7 idle hold", state_o, held);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule